// File: doc/BRIEF.md
# Add/Subtract Unit with Status Flags

This block is a registered integer adder/subtractor that keeps a four-bit condition register with negative, zero, carry and overflow bits. Each request presents two operands, an operation select (add or subtract), a select that takes the carry-in from the stored carry bit, and a flag-update bit. The result register loads on the clock edge that follows a valid request. The condition register loads on that same edge only when the flag-update bit is set.

A subtract is done as the first operand plus the inverted second operand plus a carry-in. A carry of 1 after a subtract therefore means that no borrow occurred. Carry is found by comparing the truncated result with the full-precision unsigned sum. Overflow is found by comparing the truncated result with the full-precision signed sum.

Top module: `addsub_flags`

## Requirements
- R1: While reset is active, and on the first sampling after it, the flag output is 4'b0000 ({neg,zero,carry,ovf} order, neg at bit 3) and the result output is 0.
- R2: Add computes a + b + cin, where cin = 0 unless the carry-select is set. The sum is truncated to WIDTH bits and appears on the result output one clock edge after the valid request.
- R3: Subtract computes a + ~b + cin, where cin = 1 unless the carry-select is set. The result is visible one edge after the request.
- R4: When the carry-select is set, cin is the carry flag as stored before the operation.
- R5: Flag bit 3 (neg) equals the result's top bit. Flag bit 2 (zero) is 1 exactly when every result bit is 0.
- R6: Flag bit 1 (carry) is 1 exactly when the full unsigned sum differs from the unsigned value of the truncated result.
- R7: Flag bit 0 (ovf) is 1 exactly when the full signed sum differs from the signed value of the truncated result.
- R8: A valid request with the flag-update bit clear writes the result and leaves all four flags unchanged.
- R9: When valid is low, neither the result nor the flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| use_cflag | input | 1 | Take carry-in from the stored carry flag |
| set_flags | input | 1 | Update the condition register |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| res_out | output | WIDTH | Registered result |
| flags_out | output | 4 | {neg, zero, carry, ovf} |

## Verification
Two functions can fall on the same clock edge: the carry-select reads the stored carry flag, and a flag-setting operation overwrites that same flag. The bench chains operations back to back so that an operation with use_cflag set comes right after one that changed the carry. It then checks that the chained result uses the old carry, and that the new carry comes from the chained operation itself. Flag-preserving operations are placed between flag-setting ones, and the bench checks that the flags survive them unchanged.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
   localparam int FLAG_W = 4;
   localparam int F_NEG  = 3;
   localparam int F_ZERO = 2;
   localparam int F_CARRY = 1;
   localparam int F_OVF  = 0;
   typedef struct packed {
      logic neg;
      logic zero;
      logic carry;
      logic ovf;
   } cond_t;
endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
   parameter int WIDTH = 32
) (
   input  logic             sub,
   input  logic             cin,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum,
   output logic             carry,
   output logic             ovf
);
   localparam int EXT = WIDTH + 1;
   logic [WIDTH-1:0] b_eff;
   logic [EXT-1:0]   usum;
   logic signed [EXT-1:0] ssum;

   initial begin
      if (WIDTH < 2) $error("addsub_core: WIDTH must be at least 2");
   end

   always_comb begin
      b_eff = sub ? ~b : b;
      usum  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
      ssum  = $signed({a[WIDTH-1], a}) + $signed({b_eff[WIDTH-1], b_eff})
            + $signed({{WIDTH{1'b0}}, cin});
      sum   = usum[WIDTH-1:0];
      carry = ({1'b0, sum} != usum);
      ovf   = ($signed({sum[WIDTH-1], sum}) != ssum);
   end
endmodule

// File: rtl/cond_reg.sv
module cond_reg
   import addsub_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] sum,
   input  logic             carry,
   input  logic             ovf,
   output cond_t            flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else if (load) begin
         flags.neg   <= sum[WIDTH-1];
         flags.zero  <= (sum == '0);
         flags.carry <= carry;
         flags.ovf   <= ovf;
      end
   end

   p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(flags))
      else $error("R8 flags changed without load");
   p_zero_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !(flags.zero && flags.neg))
      else $error("R5 zero and neg both set");
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
   import addsub_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             op_sub,
   input  logic             use_cflag,
   input  logic             set_flags,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] res_out,
   output logic [FLAG_W-1:0] flags_out
);
   cond_t            flags_q;
   logic             cin;
   logic [WIDTH-1:0] sum;
   logic             c_out, v_out;
   logic [WIDTH-1:0] res_q;

   initial begin
      if (WIDTH > 64) $error("addsub_flags: WIDTH above 64 not supported");
   end

   assign cin = use_cflag ? flags_q.carry : op_sub;

   addsub_core #(.WIDTH(WIDTH)) u_core (
      .sub(op_sub), .cin(cin), .a(opnd_a), .b(opnd_b),
      .sum(sum), .carry(c_out), .ovf(v_out)
   );

   cond_reg #(.WIDTH(WIDTH)) u_cond (
      .clk(clk), .rst_n(rst_n), .load(req_valid && set_flags),
      .sum(sum), .carry(c_out), .ovf(v_out), .flags(flags_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else if (req_valid) res_q <= sum;
   end

   assign res_out   = res_q;
   assign flags_out = flags_q;

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(res_out) && $stable(flags_out))
      else $error("R9 state moved while idle");
   p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !op_sub && !use_cflag |=>
         res_out == $past(opnd_a) + $past(opnd_b))
      else $error("R2 add result wrong");
   p_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && op_sub && !use_cflag |=>
         res_out == $past(opnd_a) - $past(opnd_b))
      else $error("R3 subtract result wrong");
   p_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && set_flags |=> flags_out[F_NEG] == res_out[WIDTH-1])
      else $error("R5 neg mismatch");
   p_nosf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !set_flags |=> $stable(flags_out))
      else $error("R8 flags changed");
endmodule

// File: tb/addsub_flags_tb.sv
module addsub_flags_tb;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, op_sub = 0, use_cflag = 0, set_flags = 0;
   logic [W-1:0] opnd_a = 0, opnd_b = 0;
   logic [W-1:0] res_out;
   logic [3:0]   flags_out;
   int checks = 0, errors = 0;
   logic [3:0] mflags;

   always #(CLK_PERIOD/2) clk = ~clk;

   addsub_flags #(.WIDTH(W)) u_dut (.*);

   // vector: sub, usec, setf, a, b
   typedef struct packed {
      logic sub; logic usec; logic setf; logic [W-1:0] a; logic [W-1:0] b;
   } vec_t;
   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,1'b1,32'd5,32'd7},
      '{1'b0,1'b0,1'b1,32'hFFFFFFFF,32'd1},
      '{1'b0,1'b1,1'b1,32'd10,32'd20},
      '{1'b0,1'b0,1'b1,32'h7FFFFFFF,32'd1},
      '{1'b1,1'b0,1'b1,32'd3,32'd5},
      '{1'b1,1'b0,1'b1,32'd9,32'd9},
      '{1'b1,1'b1,1'b1,32'd9,32'd4},
      '{1'b1,1'b0,1'b1,32'h80000000,32'd1},
      '{1'b0,1'b0,1'b0,32'hFFFFFFFF,32'hFFFFFFFF},
      '{1'b1,1'b1,1'b0,32'd100,32'd1},
      '{1'b0,1'b0,1'b1,32'h80000000,32'h80000000},
      '{1'b0,1'b1,1'b1,32'd0,32'd0}
   };

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run(input vec_t v, string req);
      logic cin; logic [W:0] us; longint ss; logic [W-1:0] r, be;
      logic [3:0] ef;
      be = v.sub ? ~v.b : v.b;
      cin = v.usec ? mflags[1] : v.sub;
      us = {1'b0, v.a} + {1'b0, be} + cin;
      r = us[W-1:0];
      ss = longint'($signed(v.a)) + longint'($signed(be)) + longint'(cin);
      ef = {r[W-1], r == 0, us[W], longint'($signed(r)) != ss};
      if (v.setf) mflags = ef;
      @(negedge clk);
      req_valid = 1; op_sub = v.sub; use_cflag = v.usec; set_flags = v.setf;
      opnd_a = v.a; opnd_b = v.b;
      @(negedge clk);
      req_valid = 0;
      check({req, " result"}, res_out, r);
      check({req, " flags"}, flags_out, mflags);
   endtask

   initial begin
      #(CLK_PERIOD*20000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      mflags = 0;
      #(CLK_PERIOD*2);
      check("R1 flags in reset", flags_out, 0);
      check("R1 result in reset", res_out, 0);
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      check("R1 flags after reset", flags_out, 0);
      // vector walk: R2 add, R3 sub, R4 carry chain, R5/R6/R7 flags, R8 preserve
      for (int i = 0; i < NV; i++) run(VECS[i], "R2/R3/R4/R5/R6/R7/R8 vec");
      // R4 back-to-back: carry set then adc consumes old carry
      run('{1'b0,1'b0,1'b1,32'hFFFFFFFF,32'd2}, "R6 carry gen");
      run('{1'b0,1'b1,1'b1,32'd1,32'd1}, "R4 adc uses stored carry");
      run('{1'b1,1'b1,1'b1,32'd0,32'd1}, "R4 sbc borrow");
      // R8 non-setting op after flags set keeps flags
      run('{1'b1,1'b0,1'b0,32'd1,32'd1}, "R8 flags kept");
      // R9 idle: change inputs without valid
      @(negedge clk);
      opnd_a = 32'h1234; opnd_b = 32'h1; set_flags = 1; op_sub = 0;
      @(negedge clk); @(negedge clk);
      check("R9 result idle", res_out, 32'd0);
      check("R9 flags idle", flags_out, mflags);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule